// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block is a synchronous memory that follows a double-data-rate, burst-of-four, common-I/O SRAM protocol. Every transaction moves four 18-bit words across two periods of the input clock, one word on each half. Real differential clocking is replaced by a double-rate clock `clk`. An internal phase bit marks which half of the modelled input clock each `clk` edge belongs to. An edge with the phase bit low is a rising-reference edge; an edge with the phase bit high is a falling-reference edge. The phase bit is brought out as the free-running `echo_clk`.

A host lowers `ld_n` ahead of a rising-reference edge to define a burst. At that edge it presents `rw_n` and a word address. The two low address bits choose the first word inside an aligned four-word block, and the burst then walks forward through that block with wrap-around. Write words and their per-byte enables are taken on the four `clk` edges after the load edge. The whole burst is stored at once on the fourth of those edges. Read words leave the block one and a half input-clock periods after the load, with `rvalid` marking the four beats.

Top module: `ddrb4_core`

## Requirements
- R1: A burst is defined only when `ld_n` is 0 at a rising-reference edge, meaning `echo_clk` is 0 just before that edge. At that edge the block captures `addr` and `rw_n`. A low `ld_n` at a falling-reference edge has no effect.
- R2: At a load, `rw_n` = 1 selects a read burst and `rw_n` = 0 selects a write burst.
- R3: A write burst takes `wdata` on each of the four `clk` edges that follow its load edge, one beat per edge, in burst order.
- R4: `bw_n` is sampled with each write beat. Bit 0 at 0 writes word bits 8:0, and bit 1 at 0 writes word bits 17:9. A lane whose enable is 1 keeps its former content.
- R5: Beat i of a burst (i = 0..3) addresses word {addr[7:2], (addr[1:0] + i) mod 4}.
- R6: Read beat 0 is visible after the third `clk` edge following the load edge, and beats 1 to 3 follow on the next three edges. `rvalid` is 1 for exactly those four slots. `rdata` is 0 whenever `rvalid` is 0.
- R7: Read beats 0 and 2 are launched on falling-reference edges, so `echo_clk` is 0 while they are shown. Beats 1 and 3 are launched on rising-reference edges, so `echo_clk` is 1 while they are shown.
- R8: `echo_clk` inverts on every `clk` edge outside reset, whether or not read data is present.
- R9: After an accepted load, a low `ld_n` at the next rising-reference edge is ignored. A load at the rising-reference edge after that is accepted.
- R10: A write burst updates storage on its fourth beat edge. A read loaded on that same edge returns the new data. A read loaded one burst before a write to the same words returns the old data.
- R11: While `rst` is 1, `rvalid`, `rdata` and `echo_clk` are 0 after each edge, and bursts already in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; two edges per modelled input-clock period |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low burst load strobe |
| rw_n | input | 1 | Direction at load: 1 read, 0 write |
| addr | input | 8 | Word address; bits 1:0 pick the starting word |
| bw_n | input | 2 | Active-low byte-lane write enables for the current beat |
| wdata | input | 18 | Write beat data |
| rdata | output | 18 | Read beat data, 0 when idle |
| rvalid | output | 1 | High during the four read beats |
| echo_clk | output | 1 | Free-running phase clock, toggling every `clk` edge |

## Verification
The hardest states to reach are the overlaps at the two-period load spacing. These are a read loaded on the very edge where the previous write commits, a write loaded while an earlier read is still streaming the same words, and a refused load landing exactly one rising edge after an accepted one. Directed sequences drive these at slot level: they line up on `echo_clk` and then place the strobe, the direction and the fourth write beat on chosen edges. A long random stream then mixes strobes on both phases, random directions, random start offsets and random per-beat masks over a small address window, so that later reads keep landing on words that partial writes have touched.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;

    parameter int unsigned ADDR_W = 8;
    parameter int unsigned WORD_W = 18;
    parameter int unsigned LANES  = 2;

    localparam int unsigned BEATS   = 4;
    localparam int unsigned LANE_W  = WORD_W / LANES;
    localparam int unsigned OFS_W   = $clog2(BEATS);
    localparam int unsigned BLK_W   = ADDR_W - OFS_W;
    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned RD_WAIT = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  mask_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [BLK_W-1:0]  blk_t;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    typedef struct packed {
        blk_t blk;
        ofs_t start;
        dir_e dir;
    } req_t;

    typedef struct packed {
        word_t data;
        mask_t skip;
    } beat_t;

    function automatic addr_t beat_addr(req_t r, int unsigned idx);
        ofs_t o;
        o = r.start + ofs_t'(idx);
        return {r.blk, o};
    endfunction

endpackage

// File: rtl/ddrb4_cmd.sv
module ddrb4_cmd
    import ddrb4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_n,
    input  logic  rw_n,
    input  addr_t addr,
    output logic  ph,
    output logic  accept,
    output req_t  req
);

    logic ph_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (!ph_q) begin
                hold_q <= accept;
            end
        end
    end

    always_comb begin
        accept    = !ph_q && !ld_n && !hold_q;
        req.blk   = addr[ADDR_W-1:OFS_W];
        req.start = addr[OFS_W-1:0];
        req.dir   = rw_n ? DIR_RD : DIR_WR;
    end

    assign ph = ph_q;

endmodule

// File: rtl/ddrb4_wgather.sv
module ddrb4_wgather
    import ddrb4_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  req_t                  req_in,
    input  word_t                 wdata,
    input  mask_t                 bw_n,
    output logic                  commit,
    output req_t                  cm_req,
    output beat_t [BEATS-1:0]     cm_beats
);

    logic              act_q;
    ofs_t              cnt_q;
    req_t              req_q;
    beat_t [BEATS-2:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            req_q <= '0;
        end else begin
            if (act_q) begin
                cnt_q <= cnt_q + ofs_t'(1);
                if (cnt_q == ofs_t'(BEATS-1)) begin
                    act_q <= 1'b0;
                end
            end
            if (start) begin
                act_q <= 1'b1;
                cnt_q <= '0;
                req_q <= req_in;
            end
        end
    end

    for (genvar b = 0; b < BEATS-1; b++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[b] <= '0;
            end else if (act_q && cnt_q == ofs_t'(b)) begin
                held_q[b] <= '{data: wdata, skip: bw_n};
            end
        end
        assign cm_beats[b] = held_q[b];
    end

    assign cm_beats[BEATS-1] = '{data: wdata, skip: bw_n};
    assign commit            = act_q && (cnt_q == ofs_t'(BEATS-1));
    assign cm_req            = req_q;

endmodule

// File: rtl/ddrb4_rseq.sv
module ddrb4_rseq
    import ddrb4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  req_t  req_in,
    output logic  rd_en,
    output addr_t rd_addr
);

    localparam int unsigned AGE_W = $clog2(RD_WAIT + 1);

    logic             wait_v_q;
    logic [AGE_W-1:0] wait_age_q;
    req_t             wait_req_q;
    logic             out_v_q;
    ofs_t             out_beat_q;
    req_t             out_req_q;
    logic             handoff;

    assign handoff = wait_v_q && (wait_age_q == AGE_W'(RD_WAIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_v_q   <= 1'b0;
            wait_age_q <= '0;
            wait_req_q <= '0;
        end else if (start) begin
            wait_v_q   <= 1'b1;
            wait_age_q <= '0;
            wait_req_q <= req_in;
        end else if (wait_v_q) begin
            if (handoff) begin
                wait_v_q <= 1'b0;
            end else begin
                wait_age_q <= wait_age_q + AGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v_q    <= 1'b0;
            out_beat_q <= '0;
            out_req_q  <= '0;
        end else if (handoff) begin
            out_v_q    <= 1'b1;
            out_beat_q <= '0;
            out_req_q  <= wait_req_q;
        end else if (out_v_q) begin
            out_beat_q <= out_beat_q + ofs_t'(1);
            if (out_beat_q == ofs_t'(BEATS-1)) begin
                out_v_q <= 1'b0;
            end
        end
    end

    assign rd_en   = out_v_q;
    assign rd_addr = beat_addr(out_req_q, int'(out_beat_q));

endmodule

// File: rtl/ddrb4_array.sv
module ddrb4_array
    import ddrb4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  req_t              wr_req,
    input  beat_t [BEATS-1:0] wr_beats,
    input  logic              rd_en,
    input  addr_t             rd_addr,
    output word_t             rdata,
    output logic              rvalid
);

    logic [LANES-1:0][LANE_W-1:0] rd_lanes;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we) begin
                for (int b = 0; b < BEATS; b++) begin
                    if (!wr_beats[b].skip[l]) begin
                        store[beat_addr(wr_req, b)] <= wr_beats[b].data[l*LANE_W +: LANE_W];
                    end
                end
            end
        end

        assign rd_lanes[l] = store[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_en) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rdata  <= word_t'(rd_lanes);
            rvalid <= 1'b1;
        end
    end

endmodule

// File: rtl/ddrb4_core.sv
module ddrb4_core
    import ddrb4_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_n,
    input  logic                     rw_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         bw_n,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    output logic                     rvalid,
    output logic                     echo_clk
);

    logic              ph;
    logic              load_ok;
    req_t              load_req;
    logic              wr_go;
    logic              rd_go;
    logic              wr_commit;
    req_t              wr_req;
    beat_t [BEATS-1:0] wr_beats;
    logic              rd_en;
    addr_t             rd_addr;

    ddrb4_cmd u_cmd (
        .clk    (clk),
        .rst    (rst),
        .ld_n   (ld_n),
        .rw_n   (rw_n),
        .addr   (addr),
        .ph     (ph),
        .accept (load_ok),
        .req    (load_req)
    );

    assign wr_go = load_ok && (load_req.dir == DIR_WR);
    assign rd_go = load_ok && (load_req.dir == DIR_RD);

    ddrb4_wgather u_wg (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_go),
        .req_in   (load_req),
        .wdata    (wdata),
        .bw_n     (bw_n),
        .commit   (wr_commit),
        .cm_req   (wr_req),
        .cm_beats (wr_beats)
    );

    ddrb4_rseq u_rs (
        .clk     (clk),
        .rst     (rst),
        .start   (rd_go),
        .req_in  (load_req),
        .rd_en   (rd_en),
        .rd_addr (rd_addr)
    );

    ddrb4_array u_mem (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_commit),
        .wr_req   (wr_req),
        .wr_beats (wr_beats),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assign echo_clk = ph;

endmodule

// File: rtl/ddrb4_chk.sv
module ddrb4_chk (
    input logic clk,
    input logic rst,
    input logic echo_clk,
    input logic rvalid,
    input logic load_ok
);

    logic [3:0] run_q;
    logic       rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= rvalid ? run_q + 4'd1 : 4'd0;
        end
        rst_seen <= rst;
    end

    // R8: the phase clock flips on every edge out of reset
    a_r8_echo_toggle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> echo_clk != $past(echo_clk));

    // R1: loads only on rising-reference edges
    a_r1_load_rise: assert property (@(posedge clk) disable iff (rst)
        load_ok |-> !echo_clk);

    // R9: no load on the following rising-reference edge
    a_r9_load_gap: assert property (@(posedge clk) disable iff (rst)
        load_ok |=> !load_ok ##1 !load_ok);

    // R6: valid runs come in whole bursts of four
    a_r6_run_len: assert property (@(posedge clk) disable iff (rst)
        $fell(rvalid) |-> run_q[1:0] == 2'd0);

    // R7: first beat of a run is shown in the low half of the echo clock
    a_r7_first_beat: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> !echo_clk);

    // R11: outputs quiet after a reset edge
    always @(posedge clk) begin
        if (rst_seen) begin
            a_r11_reset_quiet: assert (!rvalid && !echo_clk);
        end
    end

endmodule

bind ddrb4_core ddrb4_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .echo_clk (echo_clk),
    .rvalid   (rvalid),
    .load_ok  (load_ok)
);

// File: tb/tb_ddrb4_core.sv
module tb_ddrb4_core;
    import ddrb4_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  ld_n = 1'b1;
    logic  rw_n = 1'b1;
    addr_t addr = '0;
    mask_t bw_n = '1;
    word_t wdata = '0;
    word_t rdata;
    logic  rvalid;
    logic  echo_clk;

    always #5 clk = ~clk;

    ddrb4_core dut (
        .clk      (clk),
        .rst      (rst),
        .ld_n     (ld_n),
        .rw_n     (rw_n),
        .addr     (addr),
        .bw_n     (bw_n),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .echo_clk (echo_clk)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    edge_n = 0;
    string scen = "R11";

    // behavioural reference state
    int    m_ph, m_hold, m_wact, m_wstart, m_wblk, m_wst, m_k, m_a;
    word_t m_wd [4];
    mask_t m_wb [4];
    word_t m_old;
    mask_t m_kn;
    word_t mm [int];
    mask_t mk [int];
    bit    ev [int];
    word_t ed [int];
    mask_t ek [int];
    int    eb [int];
    bit    eecho [int];

    word_t sd [4];
    mask_t sb [4];

    function automatic int waddr(int blk, int st, int i);
        return blk * 4 + ((st + i) % 4);
    endfunction

    function automatic word_t lmask(mask_t k);
        word_t r;
        r = '0;
        for (int l = 0; l < LANES; l++) begin
            if (k[l]) r[l*LANE_W +: LANE_W] = '1;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (scenario %s) edge %0d: actual=%h expected=%h",
                     tag, scen, edge_n, act, exp);
        end
    endtask

    always @(posedge clk) begin
        edge_n++;
        if (rst) begin
            m_ph = 0; m_hold = 0; m_wact = 0;
            ev.delete(); ed.delete(); ek.delete(); eb.delete();
        end else begin
            if (m_wact != 0) begin
                m_k = edge_n - m_wstart - 1;
                m_wd[m_k] = wdata;
                m_wb[m_k] = bw_n;
                if (m_k == 3) begin
                    for (int i = 0; i < 4; i++) begin
                        m_a   = waddr(m_wblk, m_wst, i);
                        m_old = mm.exists(m_a) ? mm[m_a] : '0;
                        m_kn  = mk.exists(m_a) ? mk[m_a] : '0;
                        for (int l = 0; l < LANES; l++) begin
                            if (!m_wb[i][l]) begin
                                m_old[l*LANE_W +: LANE_W] = m_wd[i][l*LANE_W +: LANE_W];
                                m_kn[l] = 1'b1;
                            end
                        end
                        mm[m_a] = m_old;
                        mk[m_a] = m_kn;
                    end
                    m_wact = 0;
                end
            end
            if (m_ph == 0 && !ld_n && m_hold == 0) begin
                if (rw_n) begin
                    for (int i = 0; i < 4; i++) begin
                        m_a = waddr(int'(addr) / 4, int'(addr) % 4, i);
                        ev[edge_n + 3 + i] = 1'b1;
                        ed[edge_n + 3 + i] = mm.exists(m_a) ? mm[m_a] : '0;
                        ek[edge_n + 3 + i] = mk.exists(m_a) ? mk[m_a] : '0;
                        eb[edge_n + 3 + i] = i;
                    end
                end else begin
                    m_wact = 1; m_wstart = edge_n;
                    m_wblk = int'(addr) / 4; m_wst = int'(addr) % 4;
                end
                m_hold = 1;
            end else if (m_ph == 0) begin
                m_hold = 0;
            end
            m_ph = 1 - m_ph;
        end
        eecho[edge_n] = (m_ph != 0);
    end

    always @(negedge clk) begin
        if (edge_n > 0) begin
            chk(rvalid == ev.exists(edge_n), "R6", 32'(rvalid), 32'(ev.exists(edge_n)));
            if (ev.exists(edge_n)) begin
                chk((rdata & lmask(ek[edge_n])) == (ed[edge_n] & lmask(ek[edge_n])),
                    "R5", 32'(rdata), 32'(ed[edge_n]));
                chk(echo_clk == eb[edge_n][0], "R7", 32'(echo_clk), 32'(eb[edge_n][0]));
            end else begin
                chk(rdata == '0, "R6", 32'(rdata), 32'h0);
            end
            chk(echo_clk == eecho[edge_n], "R8", 32'(echo_clk), 32'(eecho[edge_n]));
        end
    end

    task automatic slot(bit l, bit r, int a, mask_t b, word_t d);
        ld_n = l; rw_n = r; addr = addr_t'(a); bw_n = b; wdata = d;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) slot(1'b1, 1'b1, 0, '1, '0);
    endtask

    task automatic align();
        while (echo_clk !== 1'b0) slot(1'b1, 1'b1, 0, '1, '0);
    endtask

    task automatic wr4(int a);
        align();
        slot(1'b0, 1'b0, a, '1, '0);
        for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 0, sb[i], sd[i]);
    endtask

    task automatic rd4(int a);
        align();
        slot(1'b0, 1'b1, a, '1, '0);
    endtask

    initial begin
        @(negedge clk);
        idle(3);
        chk(!rvalid && !echo_clk && rdata == '0, "R11", {rvalid, echo_clk}, 32'h0);
        rst = 1'b0;
        idle(2);

        scen = "R3";
        sd = '{18'h00011, 18'h10022, 18'h20033, 18'h3FF44};
        sb = '{2'b00, 2'b00, 2'b00, 2'b00};
        wr4(16);
        idle(2);
        scen = "R2";
        rd4(16);
        idle(8);

        scen = "R5";
        rd4(18);
        idle(8);
        rd4(19);
        idle(8);

        scen = "R4";
        sd = '{18'h2AAAA, 18'h15555, 18'h3C3C3, 18'h0F0F0};
        sb = '{2'b10, 2'b01, 2'b11, 2'b00};
        wr4(19);
        idle(2);
        rd4(16);
        idle(8);

        scen = "R10";
        align();
        slot(1'b0, 1'b0, 32, '1, '0);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h12345);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h23456);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h34567);
        slot(1'b0, 1'b1, 32, 2'b00, 18'h05678);
        idle(8);
        align();
        slot(1'b0, 1'b1, 33, '1, '0);
        idle(3);
        slot(1'b0, 1'b0, 33, '1, '0);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h3AAAA);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h3BBBB);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h3CCCC);
        slot(1'b1, 1'b1, 0, 2'b00, 18'h3DDDD);
        idle(2);
        rd4(33);
        idle(8);

        scen = "R9";
        align();
        slot(1'b0, 1'b1, 16, '1, '0);
        idle(1);
        slot(1'b0, 1'b1, 18, '1, '0);
        idle(1);
        slot(1'b0, 1'b1, 34, '1, '0);
        idle(10);

        scen = "R1";
        align();
        idle(1);
        slot(1'b0, 1'b1, 16, '1, '0);
        idle(8);

        scen = "R11";
        rd4(16);
        idle(2);
        rst = 1'b1;
        idle(1);
        chk(!rvalid && !echo_clk && rdata == '0, "R11", {rvalid, echo_clk}, 32'h0);
        rst = 1'b0;
        idle(8);

        scen = "R6";
        for (int i = 0; i < 3000; i++) begin
            slot(($urandom % 3) != 0, 1'($urandom), int'($urandom % 64),
                 mask_t'($urandom), word_t'($urandom));
        end
        idle(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog expired: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule